// File: doc/BRIEF.md
# MMU Internal Register Access Decoder

This block sits behind the load/store path and serves 64-bit accesses that carry an address-space identifier (ASI) and a virtual address, aimed at the control registers of an instruction MMU and a data MMU. One shared decoder turns each ASI/address pair into a single register selection. Every register has its own permission: read-only, write-only or read/write. Accesses that are misaligned, that break a permission, or that name an unknown ASI or address are reported on two separate fault outputs. A faulting access never changes state.

The request side is a valid-qualified stream with no back-pressure. A request is taken in every cycle in which `req_valid` is high, so there is no ready signal and at most one request is accepted per cycle. The response is not a handshake stream: `rsp_valid` marks the single cycle that follows each accepted request, and the receiver must take the response in that cycle. Registers that hold addresses store a value sign-extended from bit 43. Read-only pointer and fault-address values come in on plain input pins.

TLB data-access and tag-read requests leave on a strobed index port, and the array's data comes back one cycle later. Writes to the TLB data-in and demap addresses are not stored. Each one becomes a one-cycle command pulse.

Top module: `mmu_regfile_decode`

## Requirements
- R1: An access whose address has bits 2:0 non-zero raises `rsp_misalign`, and never `rsp_access_fault`. It returns zero read data, changes no register, and produces no TLB strobe and no command pulse.
- R2: The access is aligned but it is a write to a read-only location, a read of a write-only location, an unknown ASI, or an unknown address within a known ASI. Such an access raises `rsp_access_fault` with `rsp_fault_type` = 0x08. `rsp_fault_type` is 0x00 in every other response.
- R3: Writes to the TSB, tag-access, virtual-watchpoint and physical-watchpoint registers take any value. On readback, bits 63:43 all equal written bit 43, and bits 42:0 are as written.
- R4: ASI 0x58 (data side) decodes the following addresses: 0x00 tag target (read-only), 0x08 primary context, 0x10 secondary context, 0x18 fault status, 0x20 fault address (read-only, value of `ro_fault_addr_d`), 0x28 TSB, 0x30 tag access, 0x38 virtual watchpoint and 0x40 physical watchpoint. The context registers keep bits 12:0 and read zero above that. Fault status keeps all 64 bits.
- R5: ASI 0x50 (instruction side) decodes only 0x00 tag target, 0x18 fault status, 0x28 TSB and 0x30 tag access. Its registers are separate from the data-side registers.
- R6: The tag target of a side reads as follows: tag-access bits 12:0 appear in bits 60:48, and tag-access bits 63:22 appear in bits 41:0. All other bits read zero.
- R7: The following ASIs are read-only at address 0x00 only, and return the matching input pin:
  - 0x51 and 0x59: 8K pointers, from `ro_ptr8_i` and `ro_ptr8_d`.
  - 0x52 and 0x5A: 64K pointers, from `ro_ptr64_i` and `ro_ptr64_d`.
  - 0x5B: direct pointer, from `ro_direct_d`.
- R8: Data-in is write-only at address 0x00 (ASI 0x54 and 0x5C). Demap is write-only at any aligned address (ASI 0x57 and 0x5F). A write to either raises `cmd_valid` for one cycle in the response cycle, carrying the following fields:
  - `cmd_demap`: 0 for data-in, 1 for demap.
  - `cmd_side`: ASI bit 3.
  - `cmd_addr` and `cmd_data`: the request's address and data.
- R9: TLB data access (ASI 0x55, 0x5D; read/write) and TLB tag read (ASI 0x56, 0x5E; read-only) accept addresses 0x000 to 0x1F8. In the request cycle the block drives `tlb_rd` or `tlb_wr`, together with `tlb_index` = address bits 8:3, `tlb_side` = ASI bit 3 and `tlb_tag_sel` = 1 for tag read. A read returns the value that is on `tlb_rdata` in the response cycle.
- R10: A faulting access returns zero read data and produces no TLB strobe and no command pulse. Writes also return zero read data.
- R11: `rsp_valid` and the fault outputs appear exactly one cycle after each request, and `rsp_valid` is low after a cycle with no request.
- R12: After reset, every stored register reads zero, and `rsp_valid` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; always accepted |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | 64 | Virtual address |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Response cycle marker |
| rsp_rdata | output | 64 | Load data, zero on fault or store |
| rsp_misalign | output | 1 | Misaligned-address fault |
| rsp_access_fault | output | 1 | Data-access fault |
| rsp_fault_type | output | 8 | Fault-type code |
| tlb_rd | output | 1 | TLB read strobe |
| tlb_wr | output | 1 | TLB write strobe |
| tlb_side | output | 1 | 0 instruction, 1 data |
| tlb_tag_sel | output | 1 | 1 tag read, 0 data access |
| tlb_index | output | 6 | TLB entry index |
| tlb_wdata | output | 64 | TLB write data |
| tlb_rdata | input | 64 | TLB read data, one cycle after strobe |
| cmd_valid | output | 1 | Data-in / demap command pulse |
| cmd_demap | output | 1 | 1 demap, 0 data-in |
| cmd_side | output | 1 | 0 instruction, 1 data |
| cmd_addr | output | 64 | Command address |
| cmd_data | output | 64 | Command data |
| ro_ptr8_i | input | 64 | Instruction 8K pointer value |
| ro_ptr64_i | input | 64 | Instruction 64K pointer value |
| ro_ptr8_d | input | 64 | Data 8K pointer value |
| ro_ptr64_d | input | 64 | Data 64K pointer value |
| ro_direct_d | input | 64 | Data direct pointer value |
| ro_fault_addr_d | input | 64 | Data fault address value |

## Verification
The TLB strobes, index, side and write data are combinational in the request cycle. The bench therefore checks them 1 ns after driving a request, well before the capturing edge. All other results are registered one stage deep: the read data, both fault flags and the fault-type code, and the command pulse. The bench drives each request at a falling edge and samples these results at the next falling edge, exactly one rising edge later, then releases the request. The TLB model latches the index on that same rising edge, so its data is present when the response is sampled. An idle cycle after the sweep confirms that `rsp_valid` drops again.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

  localparam int DW    = 64;
  localparam int ASI_W = 8;

  localparam logic [ASI_W-1:0] ASI_I_REGS   = 8'h50;
  localparam logic [ASI_W-1:0] ASI_I_PTR8   = 8'h51;
  localparam logic [ASI_W-1:0] ASI_I_PTR64  = 8'h52;
  localparam logic [ASI_W-1:0] ASI_I_DIN    = 8'h54;
  localparam logic [ASI_W-1:0] ASI_I_TDATA  = 8'h55;
  localparam logic [ASI_W-1:0] ASI_I_TTAG   = 8'h56;
  localparam logic [ASI_W-1:0] ASI_I_DEMAP  = 8'h57;
  localparam logic [ASI_W-1:0] ASI_D_REGS   = 8'h58;
  localparam logic [ASI_W-1:0] ASI_D_PTR8   = 8'h59;
  localparam logic [ASI_W-1:0] ASI_D_PTR64  = 8'h5A;
  localparam logic [ASI_W-1:0] ASI_D_DIRECT = 8'h5B;
  localparam logic [ASI_W-1:0] ASI_D_DIN    = 8'h5C;
  localparam logic [ASI_W-1:0] ASI_D_TDATA  = 8'h5D;
  localparam logic [ASI_W-1:0] ASI_D_TTAG   = 8'h5E;
  localparam logic [ASI_W-1:0] ASI_D_DEMAP  = 8'h5F;

  // ASI bit that separates the instruction side from the data side
  localparam int SIDE_BIT = 3;

  localparam logic [7:0] FT_ACCESS = 8'h08;

  typedef enum logic [4:0] {
    RID_NONE,
    RID_TAGTGT,
    RID_PCTX,
    RID_SCTX,
    RID_FSR,
    RID_FADDR,
    RID_TSB,
    RID_TAGACC,
    RID_VWATCH,
    RID_PWATCH,
    RID_PTR8,
    RID_PTR64,
    RID_DIRECT,
    RID_DATAIN,
    RID_TLBDATA,
    RID_TLBTAG,
    RID_DEMAP
  } rid_t;

  typedef struct packed {
    rid_t rid;
    logic side;
    logic misalign;
    logic afault;
    logic ok;
  } dec_t;

endpackage

// File: rtl/mmu_asi_decode.sv
module mmu_asi_decode
  import mmu_regs_pkg::*;
#(
  parameter int TLB_IDX_W = 6
) (
  input  logic [ASI_W-1:0]     asi,
  input  logic [DW-1:0]        addr,
  input  logic                 write,
  output dec_t                 dec,
  output logic [TLB_IDX_W-1:0] tlb_idx
);

  localparam int IDX_LO = 3;
  localparam int IDX_HI = IDX_LO + TLB_IDX_W - 1;

  rid_t rid;
  logic ro, wo;
  logic at_zero, in_tlb_span;

  assign at_zero     = (addr == '0);
  assign in_tlb_span = (addr[DW-1:IDX_HI+1] == '0);
  assign tlb_idx     = addr[IDX_HI:IDX_LO];

  always_comb begin
    rid = RID_NONE;
    ro  = 1'b0;
    wo  = 1'b0;
    case (asi)
      ASI_I_REGS: begin
        case (addr)
          64'h00:  begin rid = RID_TAGTGT; ro = 1'b1; end
          64'h18:  rid = RID_FSR;
          64'h28:  rid = RID_TSB;
          64'h30:  rid = RID_TAGACC;
          default: rid = RID_NONE;
        endcase
      end
      ASI_D_REGS: begin
        case (addr)
          64'h00:  begin rid = RID_TAGTGT; ro = 1'b1; end
          64'h08:  rid = RID_PCTX;
          64'h10:  rid = RID_SCTX;
          64'h18:  rid = RID_FSR;
          64'h20:  begin rid = RID_FADDR; ro = 1'b1; end
          64'h28:  rid = RID_TSB;
          64'h30:  rid = RID_TAGACC;
          64'h38:  rid = RID_VWATCH;
          64'h40:  rid = RID_PWATCH;
          default: rid = RID_NONE;
        endcase
      end
      ASI_I_PTR8, ASI_D_PTR8: begin
        ro = 1'b1;
        if (at_zero) rid = RID_PTR8;
      end
      ASI_I_PTR64, ASI_D_PTR64: begin
        ro = 1'b1;
        if (at_zero) rid = RID_PTR64;
      end
      ASI_D_DIRECT: begin
        ro = 1'b1;
        if (at_zero) rid = RID_DIRECT;
      end
      ASI_I_DIN, ASI_D_DIN: begin
        wo = 1'b1;
        if (at_zero) rid = RID_DATAIN;
      end
      ASI_I_TDATA, ASI_D_TDATA: begin
        if (in_tlb_span) rid = RID_TLBDATA;
      end
      ASI_I_TTAG, ASI_D_TTAG: begin
        ro = 1'b1;
        if (in_tlb_span) rid = RID_TLBTAG;
      end
      ASI_I_DEMAP, ASI_D_DEMAP: begin
        wo  = 1'b1;
        rid = RID_DEMAP;
      end
      default: rid = RID_NONE;
    endcase
  end

  always_comb begin
    dec.rid      = rid;
    dec.side     = asi[SIDE_BIT];
    dec.misalign = (addr[2:0] != 3'b000);
    dec.afault   = !dec.misalign &&
                   ((rid == RID_NONE) || (write && ro) || (!write && wo));
    dec.ok       = !dec.misalign && !dec.afault;
  end

endmodule

// File: rtl/mmu_side_regs.sv
module mmu_side_regs
  import mmu_regs_pkg::*;
#(
  parameter bit FULL_SET = 1'b1,
  parameter int VA_TOP   = 43,
  parameter int CTX_W    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  rid_t          rid,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rval
);

  localparam int TT_CTX_LO = 48;
  localparam int TT_VA_SH  = 22;

  logic [DW-1:0] fsr_q, tsb_q, tagacc_q;
  logic [DW-1:0] pctx_q, sctx_q, vwatch_q, pwatch_q;
  logic [DW-1:0] wd_sext, wd_ctx, tagtgt;

  function automatic logic [DW-1:0] sext_va(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    for (int b = VA_TOP + 1; b < DW; b++) r[b] = v[VA_TOP];
    return r;
  endfunction

  assign wd_sext = sext_va(wdata);
  assign wd_ctx  = {{(DW-CTX_W){1'b0}}, wdata[CTX_W-1:0]};
  assign tagtgt  = ({{(DW-CTX_W){1'b0}}, tagacc_q[CTX_W-1:0]} << TT_CTX_LO)
                 | (tagacc_q >> TT_VA_SH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q    <= '0;
      tsb_q    <= '0;
      tagacc_q <= '0;
    end else if (wen) begin
      case (rid)
        RID_FSR:    fsr_q    <= wdata;
        RID_TSB:    tsb_q    <= wd_sext;
        RID_TAGACC: tagacc_q <= wd_sext;
        default:    ;
      endcase
    end
  end

  generate
    if (FULL_SET) begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pctx_q   <= '0;
          sctx_q   <= '0;
          vwatch_q <= '0;
          pwatch_q <= '0;
        end else if (wen) begin
          case (rid)
            RID_PCTX:   pctx_q   <= wd_ctx;
            RID_SCTX:   sctx_q   <= wd_ctx;
            RID_VWATCH: vwatch_q <= wd_sext;
            RID_PWATCH: pwatch_q <= wd_sext;
            default:    ;
          endcase
        end
      end
    end else begin : g_lean
      assign pctx_q   = '0;
      assign sctx_q   = '0;
      assign vwatch_q = '0;
      assign pwatch_q = '0;
    end
  endgenerate

  always_comb begin
    case (rid)
      RID_TAGTGT: rval = tagtgt;
      RID_FSR:    rval = fsr_q;
      RID_TSB:    rval = tsb_q;
      RID_TAGACC: rval = tagacc_q;
      RID_PCTX:   rval = pctx_q;
      RID_SCTX:   rval = sctx_q;
      RID_VWATCH: rval = vwatch_q;
      RID_PWATCH: rval = pwatch_q;
      default:    rval = '0;
    endcase
  end

endmodule

// File: rtl/mmu_regfile_decode.sv
module mmu_regfile_decode
  import mmu_regs_pkg::*;
#(
  parameter int VA_TOP    = 43,
  parameter int CTX_W     = 13,
  parameter int TLB_IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ASI_W-1:0]     req_asi,
  input  logic [DW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_misalign,
  output logic                 rsp_access_fault,
  output logic [7:0]           rsp_fault_type,
  output logic                 tlb_rd,
  output logic                 tlb_wr,
  output logic                 tlb_side,
  output logic                 tlb_tag_sel,
  output logic [TLB_IDX_W-1:0] tlb_index,
  output logic [DW-1:0]        tlb_wdata,
  input  logic [DW-1:0]        tlb_rdata,
  output logic                 cmd_valid,
  output logic                 cmd_demap,
  output logic                 cmd_side,
  output logic [DW-1:0]        cmd_addr,
  output logic [DW-1:0]        cmd_data,
  input  logic [DW-1:0]        ro_ptr8_i,
  input  logic [DW-1:0]        ro_ptr64_i,
  input  logic [DW-1:0]        ro_ptr8_d,
  input  logic [DW-1:0]        ro_ptr64_d,
  input  logic [DW-1:0]        ro_direct_d,
  input  logic [DW-1:0]        ro_fault_addr_d
);

  localparam int N_SIDES = 2;

  dec_t                 dec;
  logic [TLB_IDX_W-1:0] idx;
  logic                 go, is_tlb, is_cmd;
  logic [N_SIDES-1:0]   side_wen;
  logic [DW-1:0]        side_rval [N_SIDES];
  logic [DW-1:0]        sel_val;

  logic                 valid_q, mis_q, af_q, tlbsel_q;
  logic [DW-1:0]        rdata_q;

  mmu_asi_decode #(.TLB_IDX_W(TLB_IDX_W)) u_dec (
    .asi     (req_asi),
    .addr    (req_addr),
    .write   (req_write),
    .dec     (dec),
    .tlb_idx (idx)
  );

  assign go     = req_valid && dec.ok;
  assign is_tlb = (dec.rid == RID_TLBDATA) || (dec.rid == RID_TLBTAG);
  assign is_cmd = (dec.rid == RID_DATAIN) || (dec.rid == RID_DEMAP);

  generate
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      assign side_wen[s] = go && req_write && (dec.side == 1'(s));
      mmu_side_regs #(
        .FULL_SET (s == 1),
        .VA_TOP   (VA_TOP),
        .CTX_W    (CTX_W)
      ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (side_wen[s]),
        .rid   (dec.rid),
        .wdata (req_wdata),
        .rval  (side_rval[s])
      );
    end
  endgenerate

  always_comb begin
    case (dec.rid)
      RID_PTR8:   sel_val = dec.side ? ro_ptr8_d : ro_ptr8_i;
      RID_PTR64:  sel_val = dec.side ? ro_ptr64_d : ro_ptr64_i;
      RID_DIRECT: sel_val = ro_direct_d;
      RID_FADDR:  sel_val = ro_fault_addr_d;
      default:    sel_val = side_rval[dec.side];
    endcase
  end

  // TLB port: strobed in the request cycle
  assign tlb_rd      = go && is_tlb && !req_write;
  assign tlb_wr      = go && is_tlb && req_write;
  assign tlb_side    = dec.side;
  assign tlb_tag_sel = (dec.rid == RID_TLBTAG);
  assign tlb_index   = idx;
  assign tlb_wdata   = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      mis_q     <= 1'b0;
      af_q      <= 1'b0;
      tlbsel_q  <= 1'b0;
      rdata_q   <= '0;
      cmd_valid <= 1'b0;
      cmd_demap <= 1'b0;
      cmd_side  <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      valid_q   <= req_valid;
      mis_q     <= req_valid && dec.misalign;
      af_q      <= req_valid && dec.afault;
      tlbsel_q  <= go && is_tlb && !req_write;
      rdata_q   <= (go && !is_tlb && !req_write) ? sel_val : '0;
      cmd_valid <= go && is_cmd && req_write;
      if (go && is_cmd && req_write) begin
        cmd_demap <= (dec.rid == RID_DEMAP);
        cmd_side  <= dec.side;
        cmd_addr  <= req_addr;
        cmd_data  <= req_wdata;
      end
    end
  end

  assign rsp_valid        = valid_q;
  assign rsp_misalign     = mis_q;
  assign rsp_access_fault = af_q;
  assign rsp_fault_type   = af_q ? FT_ACCESS : 8'h00;
  assign rsp_rdata        = tlbsel_q ? tlb_rdata : rdata_q;

endmodule

// File: rtl/mmu_regfile_decode_chk.sv
module mmu_regfile_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] req_addr,
  input logic        rsp_valid,
  input logic [63:0] rsp_rdata,
  input logic        rsp_misalign,
  input logic        rsp_access_fault,
  input logic [7:0]  rsp_fault_type,
  input logic        tlb_rd,
  input logic        tlb_wr,
  input logic        cmd_valid
);

  assert_misalign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[2:0] != 3'b000) |->
      (!tlb_rd && !tlb_wr) ##1 (rsp_misalign && !rsp_access_fault && rsp_rdata == 64'h0 && !cmd_valid));

  assert_fault_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_access_fault |-> (rsp_fault_type == 8'h08));

  assert_code_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_access_fault |-> (rsp_fault_type == 8'h00));

  assert_cmd_in_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> rsp_valid);

  assert_tlb_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_rd || tlb_wr) |-> (req_valid && !(tlb_rd && tlb_wr)));

  assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_access_fault |-> (rsp_rdata == 64'h0 && !cmd_valid && !rsp_misalign));

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_misalign && !rsp_access_fault));

endmodule

bind mmu_regfile_decode mmu_regfile_decode_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .req_valid        (req_valid),
  .req_addr         (req_addr),
  .rsp_valid        (rsp_valid),
  .rsp_rdata        (rsp_rdata),
  .rsp_misalign     (rsp_misalign),
  .rsp_access_fault (rsp_access_fault),
  .rsp_fault_type   (rsp_fault_type),
  .tlb_rd           (tlb_rd),
  .tlb_wr           (tlb_wr),
  .cmd_valid        (cmd_valid)
);

// File: tb/mmu_regfile_decode_test.sv
`timescale 1ns/1ps
module mmu_regfile_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_asi = '0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic        rsp_valid, rsp_misalign, rsp_access_fault;
  logic [63:0] rsp_rdata;
  logic [7:0]  rsp_fault_type;
  logic        tlb_rd, tlb_wr, tlb_side, tlb_tag_sel;
  logic [5:0]  tlb_index;
  logic [63:0] tlb_wdata, tlb_rdata;
  logic        cmd_valid, cmd_demap, cmd_side;
  logic [63:0] cmd_addr, cmd_data;

  localparam logic [63:0] P8I  = 64'h1111_2222_3333_4440;
  localparam logic [63:0] P64I = 64'h5555_6666_7777_8880;
  localparam logic [63:0] P8D  = 64'h9999_AAAA_BBBB_CCC0;
  localparam logic [63:0] P64D = 64'hDDDD_EEEE_FFFF_0000;
  localparam logic [63:0] PDIR = 64'h0F0F_1E1E_2D2D_3C30;
  localparam logic [63:0] FADR = 64'h7654_3210_FEDC_BA98;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // TLB array model: latches the strobed index, answers next cycle
  logic       l_side = 1'b0, l_tag = 1'b0;
  logic [5:0] l_idx = '0;
  always @(posedge clk) if (tlb_rd) begin
    l_side <= tlb_side; l_tag <= tlb_tag_sel; l_idx <= tlb_index;
  end
  assign tlb_rdata = 64'hC300_0000_0000_0000 | (64'(l_side) << 40) |
                     (64'(l_tag) << 32) | 64'(l_idx);

  mmu_regfile_decode uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_asi(req_asi), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign),
    .rsp_access_fault(rsp_access_fault), .rsp_fault_type(rsp_fault_type),
    .tlb_rd(tlb_rd), .tlb_wr(tlb_wr), .tlb_side(tlb_side), .tlb_tag_sel(tlb_tag_sel),
    .tlb_index(tlb_index), .tlb_wdata(tlb_wdata), .tlb_rdata(tlb_rdata),
    .cmd_valid(cmd_valid), .cmd_demap(cmd_demap), .cmd_side(cmd_side),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ro_ptr8_i(P8I), .ro_ptr64_i(P64I), .ro_ptr8_d(P8D), .ro_ptr64_d(P64D),
    .ro_direct_d(PDIR), .ro_fault_addr_d(FADR)
  );

  // bench register model: index 0 instruction side, 1 data side
  logic [63:0] m_fsr[2], m_tsb[2], m_tac[2];
  logic [63:0] m_pctx, m_sctx, m_vwp, m_pwp;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{20{v[43]}}, v[43:0]};
  endfunction

  function automatic logic [63:0] ttgt(input logic [63:0] t);
    return ({51'b0, t[12:0]} << 48) | (t >> 22);
  endfunction

  // codes: 1 tagtgt,2 pctx,3 sctx,4 fsr,5 faddr,6 tsb,7 tagacc,8 vwp,9 pwp,
  // 10 ptr8,11 ptr64,12 direct,13 datain,14 tlbdata,15 tlbtag,16 demap
  function automatic int reg_code(input logic [7:0] a, input logic [63:0] ad);
    if (a == 8'h50 || a == 8'h58) begin
      if (ad == 64'h00) return 1;
      if (ad == 64'h18) return 4;
      if (ad == 64'h28) return 6;
      if (ad == 64'h30) return 7;
      if (a == 8'h58) begin
        if (ad == 64'h08) return 2;
        if (ad == 64'h10) return 3;
        if (ad == 64'h20) return 5;
        if (ad == 64'h38) return 8;
        if (ad == 64'h40) return 9;
      end
      return 0;
    end
    if (a == 8'h51 || a == 8'h59) return (ad == 0) ? 10 : 0;
    if (a == 8'h52 || a == 8'h5A) return (ad == 0) ? 11 : 0;
    if (a == 8'h5B) return (ad == 0) ? 12 : 0;
    if (a == 8'h54 || a == 8'h5C) return (ad == 0) ? 13 : 0;
    if (a == 8'h55 || a == 8'h5D) return (ad <= 64'h1F8) ? 14 : 0;
    if (a == 8'h56 || a == 8'h5E) return (ad <= 64'h1F8) ? 15 : 0;
    if (a == 8'h57 || a == 8'h5F) return 16;
    return 0;
  endfunction

  function automatic logic [63:0] model_read(input int c, input bit s);
    case (c)
      1: return ttgt(m_tac[s]);
      2: return m_pctx;
      3: return m_sctx;
      4: return m_fsr[s];
      5: return FADR;
      6: return m_tsb[s];
      7: return m_tac[s];
      8: return m_vwp;
      9: return m_pwp;
      10: return s ? P8D : P8I;
      11: return s ? P64D : P64I;
      12: return PDIR;
      default: return 64'h0;
    endcase
  endfunction

  function automatic string req_of(input int c, input bit s);
    if (c == 1) return "R6";
    if (c == 5 || (c >= 10 && c <= 12)) return "R7";
    if (c == 6 || c == 7 || c == 8 || c == 9) return "R3";
    return s ? "R4" : "R5";
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic access(input bit wr, input logic [7:0] a, input logic [63:0] ad,
                        input logic [63:0] wd);
    int c; bit s, mis, ro, wo, af, ok, tl, cm;
    logic [63:0] expv;
    c   = reg_code(a, ad);
    s   = a[3];
    mis = (ad[2:0] != 3'b000);
    ro  = (c == 1 || c == 5 || c == 10 || c == 11 || c == 12 || c == 15);
    wo  = (c == 13 || c == 16);
    af  = !mis && (c == 0 || (wr && ro) || (!wr && wo));
    ok  = !mis && !af;
    tl  = ok && (c == 14 || c == 15);
    cm  = ok && wr && (c == 13 || c == 16);
    expv = (ok && !wr) ? (tl ? (64'hC300_0000_0000_0000 | (64'(s) << 40) |
                                64'(c == 15) << 32 | 64'(ad[8:3]))
                             : model_read(c, s)) : 64'h0;
    req_valid = 1'b1; req_write = wr; req_asi = a; req_addr = ad; req_wdata = wd;
    #1;
    chk("R9 tlb_rd", 64'(tlb_rd), 64'(tl && !wr));
    chk("R9 tlb_wr", 64'(tlb_wr), 64'(tl && wr));
    if (tl) begin
      chk("R9 tlb_index", 64'(tlb_index), 64'(ad[8:3]));
      chk("R9 tlb_side", 64'(tlb_side), 64'(s));
      chk("R9 tlb_tag_sel", 64'(tlb_tag_sel), 64'(c == 15));
      if (wr) chk("R9 tlb_wdata", tlb_wdata, wd);
    end
    @(negedge clk);
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R1 misalign", 64'(rsp_misalign), 64'(mis));
    chk("R2 access fault", 64'(rsp_access_fault), 64'(af));
    chk("R2 fault type", 64'(rsp_fault_type), af ? 64'h08 : 64'h00);
    chk(ok ? req_of(c, s) : "R10", rsp_rdata, expv);
    chk("R8 cmd_valid", 64'(cmd_valid), 64'(cm));
    if (cm) begin
      chk("R8 cmd_demap", 64'(cmd_demap), 64'(c == 16));
      chk("R8 cmd_side", 64'(cmd_side), 64'(s));
      chk("R8 cmd_addr", cmd_addr, ad);
      chk("R8 cmd_data", cmd_data, wd);
    end
    if (ok && wr) begin
      case (c)
        2: m_pctx = {51'b0, wd[12:0]};
        3: m_sctx = {51'b0, wd[12:0]};
        4: m_fsr[s] = wd;
        6: m_tsb[s] = sx(wd);
        7: m_tac[s] = sx(wd);
        8: m_vwp = sx(wd);
        9: m_pwp = sx(wd);
        default: ;
      endcase
    end
    req_valid = 1'b0;
  endtask

  logic [63:0] addrs [15];

  task automatic sweep(input bit wr, input int seed);
    int n = seed;
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 15; k++) begin
        logic [63:0] wd;
        wd = 64'h0123_4567_89AB_CDEF ^ {8'(a), 56'b0} ^ (addrs[k] << 20) ^
             ((n % 2 == 1) ? 64'h0000_0800_0000_0000 : 64'h0);
        access(wr, 8'(a), addrs[k], wd);
        n++;
      end
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    addrs = '{64'h0, 64'h8, 64'h10, 64'h18, 64'h20, 64'h28, 64'h30, 64'h38,
              64'h40, 64'h48, 64'h1F8, 64'h200, 64'h3, 64'h1FC,
              64'hFFFF_FFFF_FFFF_FFF8};
    for (int s = 0; s < 2; s++) begin m_fsr[s] = 0; m_tsb[s] = 0; m_tac[s] = 0; end
    m_pctx = 0; m_sctx = 0; m_vwp = 0; m_pwp = 0;
    repeat (3) @(negedge clk);
    chk("R12 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R12 cmd_valid in reset", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    sweep(1'b0, 0);      // R12: all stored registers read zero
    sweep(1'b1, 1);
    sweep(1'b0, 0);
    // R3 directed: bit 43 set and clear
    access(1'b1, 8'h58, 64'h28, 64'h0000_0800_0000_0000);
    access(1'b0, 8'h58, 64'h28, 64'h0);
    chk("R3 sext ones", m_tsb[1], 64'hFFFF_F800_0000_0000);
    access(1'b1, 8'h50, 64'h30, 64'hFFFF_F000_0000_1234);
    access(1'b0, 8'h50, 64'h00, 64'h0);
    chk("R6 model tagacc", m_tac[0], 64'h0000_0000_0000_1234);
    // misaligned write to a writable register leaves it unchanged (R1)
    access(1'b1, 8'h58, 64'h0D, 64'hDEAD_BEEF_0000_0000);
    access(1'b0, 8'h58, 64'h08, 64'h0);
    @(negedge clk);
    chk("R11 rsp_valid idle", 64'(rsp_valid), 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule